// File: doc/BRIEF.md
# Palette Lookup Table with Sequenced Host Loading

This block holds a 256-entry color palette, each entry a 24-bit RGB triple with 8 bits per component. A host loads it through two write ports that share one strobe: an index port that picks the entry to fill, and a data port that takes one component per write. An internal component counter steps red, green, blue. On the blue write the whole triple is stored in one step. The entry pointer then moves to the next entry, so a host can fill a run of entries with a single index write followed by a stream of data writes.

Host words are 16 bits wide. On the data port the component is the upper byte of the word, and the lower byte is dropped. On the index port the word must fit in 8 bits. A word with any upper bit set does not name a valid entry, and the block ignores it.

A display pipeline reads the table on a separate port. It presents an 8-bit pixel index and gets the 24-bit color one clock later. Host activity never stalls this read port.

Top module: `palette_lut`

## Requirements
- R1: While reset is asserted, `pix_rgb` is 0. After reset the entry pointer is 0 and the component counter is at red, so data writes made with no prior index write fill entry 0 onward.
- R2: A host write with `host_port`=0 and `host_wdata[15:8]`=0 sets the entry pointer to `host_wdata[7:0]` and returns the component counter to red.
- R3: A host write with `host_port`=0 and any bit of `host_wdata[15:8]` set changes neither the entry pointer nor the component counter.
- R4: Host writes with `host_port`=1 take `host_wdata[15:8]` as the component value, in the order red, green, blue. `host_wdata[7:0]` is ignored.
- R5: The table entry changes only on the blue write. After only red, or only red and green, have been written, the entry still reads its previous value.
- R6: After a blue write the entry pointer increments by one, wrapping from 255 to 0, and the component counter returns to red.
- R7: `pix_rgb` shows the entry addressed by `pix_idx` at the previous rising clock edge. The format is red in [23:16], green in [15:8] and blue in [7:0].
- R8: If a pixel read and a blue commit address the same entry on the same edge, the read returns the old value. The following edge returns the new value.
- R9: When `host_we` is 0, the values on `host_port` and `host_wdata` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one write per cycle |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 16 | Host word: entry index on the index port, component in the upper byte on the data port |
| pix_idx | input | 8 | Pixel-side palette index |
| pix_rgb | output | 24 | Palette color for the index of the previous cycle |

## Verification
The hardest state to reach from the ports is a blue commit landing on the same entry, and on the same edge, as a pixel read. The bench reaches it by tracking the pointer and component counter in its own model. When its model says the next data write is blue, it drives that write together with a pixel read of the current pointer. It then checks the old color on the first edge and the new color on the next. Further directed cases cover a rejected index arriving mid-triple, idle cycles with the strobe low, and the 255-to-0 pointer wrap after a full streaming fill. Seeded random mixes of index and data writes, interleaved with pixel reads, cover the rest.

// File: rtl/palette_pkg.sv
package palette_pkg;

    // Component counter state; the order is the load order on the data port.
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

endpackage

// File: rtl/palette_seq.sv
module palette_seq
    import palette_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8,
    parameter int HOST_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                sel_data,
    input  logic [HOST_W-1:0]   wdata,
    output logic                commit,
    output logic [IDX_W-1:0]    commit_addr,
    output logic [3*CH_W-1:0]   commit_rgb,
    output logic [IDX_W-1:0]    cur_idx,
    output chan_e               cur_chan
);

    localparam int HI_W = HOST_W - IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        chan_e            chan;
        logic [CH_W-1:0]  red;
        logic [CH_W-1:0]  grn;
    } seq_t;

    seq_t            s_d, s_q;
    logic            idx_ok;
    logic [CH_W-1:0] comp;

    assign idx_ok = (wdata[HOST_W-1 -: HI_W] == '0);
    assign comp   = wdata[HOST_W-1 -: CH_W];

    always_comb begin
        s_d    = s_q;
        commit = 1'b0;
        if (wr_en) begin
            if (!sel_data) begin
                if (idx_ok) begin
                    s_d.idx  = wdata[IDX_W-1:0];
                    s_d.chan = CH_RED;
                end
            end else begin
                unique case (s_q.chan)
                    CH_RED: begin
                        s_d.red  = comp;
                        s_d.chan = CH_GREEN;
                    end
                    CH_GREEN: begin
                        s_d.grn  = comp;
                        s_d.chan = CH_BLUE;
                    end
                    default: begin
                        commit   = 1'b1;
                        s_d.idx  = s_q.idx + 1'b1;
                        s_d.chan = CH_RED;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, chan: CH_RED, red: '0, grn: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign commit_addr = s_q.idx;
    assign commit_rgb  = {s_q.red, s_q.grn, comp};
    assign cur_idx     = s_q.idx;
    assign cur_chan    = s_q.chan;

endmodule

// File: rtl/palette_ram.sv
module palette_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read sees the array before this edge's write: old data on collision.
    assign rd_d = mem[raddr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8,
    parameter int HOST_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic                host_port,
    input  logic [HOST_W-1:0]   host_wdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*CH_W-1:0]   pix_rgb
);

    localparam int RGB_W = 3 * CH_W;

    logic             seq_commit;
    logic [IDX_W-1:0] seq_addr;
    logic [RGB_W-1:0] seq_rgb;
    logic [IDX_W-1:0] seq_idx;
    chan_e            seq_chan;

    palette_seq #(
        .IDX_W  (IDX_W),
        .CH_W   (CH_W),
        .HOST_W (HOST_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (host_we),
        .sel_data    (host_port),
        .wdata       (host_wdata),
        .commit      (seq_commit),
        .commit_addr (seq_addr),
        .commit_rgb  (seq_rgb),
        .cur_idx     (seq_idx),
        .cur_chan    (seq_chan)
    );

    palette_ram #(
        .ADDR_W (IDX_W),
        .DATA_W (RGB_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seq_commit),
        .waddr (seq_addr),
        .wdata (seq_rgb),
        .raddr (pix_idx),
        .rdata (pix_rgb)
    );

endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
    import palette_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int HOST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic              host_port,
    input logic [HOST_W-1:0] host_wdata,
    input logic [IDX_W-1:0]  cur_idx,
    input chan_e             cur_chan,
    input logic              commit
);

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_port && host_wdata[HOST_W-1:IDX_W] == '0)
        |=> (cur_idx == $past(host_wdata[IDX_W-1:0]) && cur_chan == CH_RED)); // R2

    AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_port && host_wdata[HOST_W-1:IDX_W] != '0)
        |=> ($stable(cur_idx) && $stable(cur_chan))); // R3

    AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_chan != CH_BLUE) |-> !commit); // R5

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cur_idx == $past(cur_idx) + 1'b1 && cur_chan == CH_RED)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> ($stable(cur_idx) && $stable(cur_chan))); // R9

endmodule

bind palette_lut palette_lut_chk #(
    .IDX_W  (IDX_W),
    .HOST_W (HOST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_port  (host_port),
    .host_wdata (host_wdata),
    .cur_idx    (seq_idx),
    .cur_chan   (seq_chan),
    .commit     (seq_commit)
);

// File: tb/test_palette_lut.sv
module test_palette_lut;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the palette and the loading state
    logic [23:0] exp_mem [256];
    logic [7:0]  m_idx = '0;
    int          m_ch  = 0;
    logic [7:0]  m_r = '0, m_g = '0;

    always #4 clk = ~clk;

    palette_lut i_palette_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_port  (host_port),
        .host_wdata (host_wdata),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb)
    );

    function automatic void m_write(bit port, logic [15:0] v);
        if (!port) begin
            if (v[15:8] == 8'h00) begin
                m_idx = v[7:0];
                m_ch  = 0;
            end
        end else begin
            case (m_ch)
                0: begin m_r = v[15:8]; m_ch = 1; end
                1: begin m_g = v[15:8]; m_ch = 2; end
                default: begin
                    exp_mem[m_idx] = {m_r, m_g, v[15:8]};
                    m_idx = m_idx + 8'd1;
                    m_ch  = 0;
                end
            endcase
        end
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic do_write(bit port, logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1; host_port = port; host_wdata = v;
        m_write(port, v);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic read_chk(logic [7:0] a, string tag);
        @(negedge clk);
        pix_idx = a;
        @(negedge clk);
        check(tag, pix_rgb, exp_mem[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] old;
        logic [7:0]  a;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;

        // R1: reset value
        repeat (3) @(negedge clk);
        check("R1 reset output", pix_rgb, 24'h0);
        rst_n = 1'b1;

        // R1/R4/R6: stream fill from entry 0 with no index write, wraps back to 0
        for (int k = 0; k < 256; k++) begin
            for (int c = 0; c < 3; c++) begin
                do_write(1'b1, 16'($urandom));
            end
        end
        check("R6 pointer wrap model", {16'h0, m_idx}, 24'h0);
        read_chk(8'd0,   "R1 entry0 after reset");
        read_chk(8'd255, "R6 entry255");
        read_chk(8'd128, "R4 entry128");
        // Wrapped pointer: next triple goes to entry 0
        do_write(1'b1, 16'hA1FF); do_write(1'b1, 16'hB2EE); do_write(1'b1, 16'hC3DD);
        read_chk(8'd0, "R6 wrap write entry0");
        check("R4 component order", exp_mem[0], 24'hA1B2C3);

        // R2/R5: index load, partial triple invisible
        do_write(1'b0, 16'h0010);
        old = exp_mem[8'h10];
        do_write(1'b1, 16'h1111);
        read_chk(8'h10, "R5 after red");
        do_write(1'b1, 16'h2222);
        read_chk(8'h10, "R5 after green");
        check("R5 unchanged", exp_mem[8'h10], old);
        do_write(1'b1, 16'h3333);
        read_chk(8'h10, "R2 entry committed");
        do_write(1'b1, 16'h4400); do_write(1'b1, 16'h5500); do_write(1'b1, 16'h6600);
        read_chk(8'h11, "R6 advance to next");

        // R3: rejected index mid-triple
        do_write(1'b0, 16'h0020);
        do_write(1'b1, 16'h7A00);
        do_write(1'b0, 16'h0130);
        do_write(1'b1, 16'h7B00);
        do_write(1'b1, 16'h7C00);
        read_chk(8'h20, "R3 bad index ignored");
        check("R3 triple value", exp_mem[8'h20], 24'h7A7B7C);

        // R9: strobe low with toggling inputs
        do_write(1'b0, 16'h0040);
        do_write(1'b1, 16'h9100);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            host_port = j[0]; host_wdata = 16'($urandom);
        end
        do_write(1'b1, 16'h9200);
        do_write(1'b1, 16'h9300);
        read_chk(8'h40, "R9 idle inputs ignored");
        check("R9 triple value", exp_mem[8'h40], 24'h919293);

        // R7: one-cycle latency
        @(negedge clk); pix_idx = 8'h10;
        @(negedge clk); pix_idx = 8'h40;
        #1 check("R7 before edge", pix_rgb, exp_mem[8'h10]);
        @(negedge clk);
        check("R7 after edge", pix_rgb, exp_mem[8'h40]);

        // R8: commit and read collide on same entry
        do_write(1'b0, 16'h0050);
        do_write(1'b1, 16'hDE00); do_write(1'b1, 16'hAD00);
        a = m_idx;
        old = exp_mem[a];
        @(negedge clk);
        host_we = 1'b1; host_port = 1'b1; host_wdata = 16'hBE00; pix_idx = a;
        m_write(1'b1, 16'hBE00);
        @(negedge clk);
        host_we = 1'b0;
        check("R8 collision old data", pix_rgb, old);
        @(negedge clk);
        check("R8 collision new data", pix_rgb, 24'hDEADBE);

        // Random mix, R2 R3 R4 R6 R7
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 10 < 2) begin
                if ($urandom % 8 == 0)
                    do_write(1'b0, {8'(1 + $urandom % 255), 8'($urandom)});
                else
                    do_write(1'b0, {8'h00, 8'($urandom)});
            end else begin
                do_write(1'b1, 16'($urandom));
            end
            read_chk(8'($urandom), "R7 random read");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule